// File: doc/BRIEF.md
# Carry and Overflow Flag ALU

This block is the flag-driven arithmetic slice of a small RISC core whose status word holds one condition bit, called T here. Every cycle the core hands it a 16-bit instruction word, the two register operands (source Rm and destination Rn) and the present T. The block returns the value to write back to Rn, the destination index, and the next T.

One shared bit does three jobs. It is the carry-in for add, the borrow-in for subtract and negate, and the carry, borrow or overflow result afterwards. The forms that check for overflow ignore the incoming T and replace it with the signed-overflow indication. A rotate through T is handled by the same path. Any other instruction word passes Rn and T through unchanged and raises a flag telling the core that this unit did not handle it.

By default the outputs are registered, so results appear one clock after the inputs. A parameter selects a purely combinational variant instead.

Top module: `tflag_alu`

## Requirements
- R1: While reset is low, out_valid, unsupported, rd_idx, result and t_out are all zero. With the default registered output, out_valid equals in_valid from the previous cycle, and every other output refers to that same cycle's inputs.
- R2: Operations are recognised from instruction bits 15:12 and 3:0 only (bits 7:0 for the rotate). rd_idx returns instruction bits 11:8 for every accepted word.
- R3: A word of the form 0x3nmE is add with carry. result = Rn + Rm + T, and t_out is 1 when either the first add or the add of T carries out of bit 31.
- R4: A word of the form 0x3nmA is subtract with borrow. result = Rn - Rm - T, and t_out is 1 when either subtraction step borrows.
- R5: A word of the form 0x6nmA is negate with borrow. result = 0 - Rm - T, and t_out is 1 when 0 - Rm is nonzero or when taking T away from it borrows.
- R6: A word of the form 0x3nmF is add with overflow check. result = Rn + Rm, and t_out is 1 only when both operands have the same sign and the sign of the result differs from it. The incoming T has no effect.
- R7: A word of the form 0x3nmB is subtract with overflow check. result = Rn - Rm, and t_out is 1 only when the operand signs differ and the sign of the result differs from the sign of Rn. The incoming T has no effect.
- R8: A word of the form 0x4n24 is rotate left through T. result = {Rn[30:0], T} and t_out = Rn[31].
- R9: Any other accepted word sets unsupported to 1, returns result = Rn and leaves t_out equal to t_in.
- R10: While in_valid is low, out_valid and unsupported stay at 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | The instruction and operands are valid |
| insn | input | 16 | Instruction word |
| rm_val | input | 32 | Source operand Rm |
| rn_val | input | 32 | Destination operand Rn |
| t_in | input | 1 | Current T bit |
| out_valid | output | 1 | The result is valid |
| unsupported | output | 1 | The instruction is not handled by this unit |
| rd_idx | output | 4 | Destination register index |
| result | output | 32 | Value to write back to Rn |
| t_out | output | 1 | Next T bit |

## Verification
The hardest case to reach is the second carry or borrow step. In it, T alone pushes the value across the 32-bit boundary, while the first step stays clean: an add where Rn + Rm is exactly 0xFFFFFFFF, or a subtract or negate where the first difference is exactly zero. Random operands almost never produce this. The stimulus therefore crosses the extreme values 0x00000000, 0xFFFFFFFF, 0x7FFFFFFF and 0x80000000 for both operands with T both clear and set, and adds hand-picked vectors that land on these boundaries.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;

    localparam int DATA_W = 32;
    localparam int INSN_W = 16;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADC  = 3'd1,
        OP_SBB  = 3'd2,
        OP_NGB  = 3'd3,
        OP_ADDO = 3'd4,
        OP_SUBO = 3'd5,
        OP_RCL  = 3'd6
    } alu_op_e;

    typedef struct packed {
        logic              valid;
        logic              unsup;
        logic [IDX_W-1:0]  rd;
        logic [DATA_W-1:0] res;
        logic              t;
    } alu_out_s;

endpackage

// File: rtl/tflag_alu_decode.sv
module tflag_alu_decode
    import tflag_alu_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int XW = IDX_W
) (
    input  logic [IW-1:0] insn,
    output alu_op_e       op,
    output logic          unsup,
    output logic [XW-1:0] rd
);
    localparam int RD_LSB = 8;

    logic [3:0] hi_nib;
    logic [3:0] lo_nib;
    logic [7:0] lo_byte;

    always_comb begin
        hi_nib  = insn[IW-1 -: 4];
        lo_nib  = insn[3:0];
        lo_byte = insn[7:0];
        rd      = insn[RD_LSB +: XW];
        op      = OP_PASS;
        unique case (hi_nib)
            4'h3: begin
                case (lo_nib)
                    4'hE:    op = OP_ADC;
                    4'hA:    op = OP_SBB;
                    4'hF:    op = OP_ADDO;
                    4'hB:    op = OP_SUBO;
                    default: op = OP_PASS;
                endcase
            end
            4'h6: op = (lo_nib == 4'hA) ? OP_NGB : OP_PASS;
            4'h4: op = (lo_byte == 8'h24) ? OP_RCL : OP_PASS;
            default: op = OP_PASS;
        endcase
        unsup = (op == OP_PASS);
    end

endmodule

// File: rtl/tflag_alu_arith.sv
module tflag_alu_arith
    import tflag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] rm,
    input  logic [W-1:0] rn,
    input  logic         t,
    output logic [W-1:0] res,
    output logic         t_nxt
);
    localparam int MSB = W - 1;

    logic [W:0]   add1;
    logic [W:0]   add2;
    logic [W-1:0] sub1;
    logic [W-1:0] sub2;
    logic         brw1;
    logic         brw2;
    logic [W-1:0] neg1;
    logic [W-1:0] neg2;
    logic         neg_nz;
    logic [W-1:0] plain_sum;
    logic [W-1:0] plain_dif;
    logic         add_ovf;
    logic         sub_ovf;
    logic [W-1:0] t_ext;

    always_comb begin
        t_ext     = {{(W-1){1'b0}}, t};

        // carry chain in two steps, each with its own carry out
        add1      = {1'b0, rn} + {1'b0, rm};
        add2      = {1'b0, add1[W-1:0]} + {1'b0, t_ext};

        // borrow chain in two steps
        sub1      = rn - rm;
        brw1      = (rm > rn);
        sub2      = sub1 - t_ext;
        brw2      = t & (sub1 == '0);

        // negate from zero, then take T away
        neg1      = '0 - rm;
        neg_nz    = (neg1 != '0);
        neg2      = neg1 - t_ext;

        // signed overflow forms
        plain_sum = rn + rm;
        plain_dif = rn - rm;
        add_ovf   = (rn[MSB] == rm[MSB]) & (plain_sum[MSB] != rn[MSB]);
        sub_ovf   = (rn[MSB] != rm[MSB]) & (plain_dif[MSB] != rn[MSB]);

        res   = rn;
        t_nxt = t;
        unique case (op)
            OP_ADC: begin
                res   = add2[W-1:0];
                t_nxt = add1[W] | add2[W];
            end
            OP_SBB: begin
                res   = sub2;
                t_nxt = brw1 | brw2;
            end
            OP_NGB: begin
                res   = neg2;
                t_nxt = neg_nz | (t & ~neg_nz);
            end
            OP_ADDO: begin
                res   = plain_sum;
                t_nxt = add_ovf;
            end
            OP_SUBO: begin
                res   = plain_dif;
                t_nxt = sub_ovf;
            end
            OP_RCL: begin
                res   = {rn[W-2:0], t};
                t_nxt = rn[MSB];
            end
            default: begin
                res   = rn;
                t_nxt = t;
            end
        endcase
    end

endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
    import tflag_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rn_val,
    input  logic              t_in,
    output logic              out_valid,
    output logic              unsupported,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] result,
    output logic              t_out
);
    alu_op_e           dec_op;
    logic              dec_unsup;
    logic [IDX_W-1:0]  dec_rd;
    logic [DATA_W-1:0] ar_res;
    logic              ar_t;
    alu_out_s          out_d;
    alu_out_s          out_q;

    tflag_alu_decode #(.IW(INSN_W), .XW(IDX_W)) u_dec (
        .insn  (insn),
        .op    (dec_op),
        .unsup (dec_unsup),
        .rd    (dec_rd)
    );

    tflag_alu_arith #(.W(DATA_W)) u_arith (
        .op    (dec_op),
        .rm    (rm_val),
        .rn    (rn_val),
        .t     (t_in),
        .res   (ar_res),
        .t_nxt (ar_t)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.valid = 1'b1;
            out_d.unsup = dec_unsup;
            out_d.rd    = dec_rd;
            out_d.res   = ar_res;
            out_d.t     = ar_t;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end
        end else begin : g_comb
            always_comb begin
                out_q = rst_n ? out_d : '0;
            end
        end
    endgenerate

    assign out_valid   = out_q.valid;
    assign unsupported = out_q.unsup;
    assign rd_idx      = out_q.rd;
    assign result      = out_q.res;
    assign t_out       = out_q.t;

endmodule

// File: rtl/tflag_alu_chk.sv
module tflag_alu_chk
    import tflag_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [INSN_W-1:0] insn,
    input logic [DATA_W-1:0] rm_val,
    input logic [DATA_W-1:0] rn_val,
    input logic              t_in,
    input logic              out_valid,
    input logic              unsupported,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] result,
    input logic              t_out
);
    generate
        if (REG_OUT) begin : g_seq
            // R1
            valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> (out_valid && rd_idx == $past(insn[11:8])));

            // R10
            idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && !unsupported));

            // R6
            addo_mixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && insn[15:12] == 4'h3 && insn[3:0] == 4'hF &&
                 rn_val[DATA_W-1] != rm_val[DATA_W-1]) |=> !t_out);

            // R8
            rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && insn[15:12] == 4'h4 && insn[7:0] == 8'h24) |=>
                (t_out == $past(rn_val[DATA_W-1]) && result[0] == $past(t_in)));

            // R9
            passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && unsupported) |-> (result == $past(rn_val) && t_out == $past(t_in)));

            // R3
            adc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && insn[15:12] == 4'h3 && insn[3:0] == 4'hE &&
                 rm_val == '0 && !t_in) |=> (result == $past(rn_val) && !t_out));
        end else begin : g_cmb
            // R10
            always_comb begin
                comb_idle_chk: assert (!rst_n || in_valid || (!out_valid && !unsupported));
            end
        end
    endgenerate

endmodule

bind tflag_alu tflag_alu_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .insn        (insn),
    .rm_val      (rm_val),
    .rn_val      (rn_val),
    .t_in        (t_in),
    .out_valid   (out_valid),
    .unsupported (unsupported),
    .rd_idx      (rd_idx),
    .result      (result),
    .t_out       (t_out)
);

// File: tb/tflag_alu_tb.sv
module tflag_alu_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] op;
        logic [31:0] rm;
        logic [31:0] rn;
        logic        t;
        logic [31:0] er;
        logic        et;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{16'h312E, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1},
        '{16'h3A5E, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b1},
        '{16'h370E, 32'h0000_0002, 32'h0000_0001, 1'b1, 32'h0000_0004, 1'b0},
        '{16'h324A, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{16'h3F1A, 32'h0000_0003, 32'h0000_0005, 1'b1, 32'h0000_0001, 1'b0},
        '{16'h613A, 32'h0000_0000, 32'h1234_5678, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{16'h6C2A, 32'h0000_0001, 32'h0000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1},
        '{16'h600A, 32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 32'h0000_0000, 1'b0},
        '{16'h333F, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 32'h8000_0000, 1'b1},
        '{16'h3B4F, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 32'h7FFF_FFFF, 1'b1},
        '{16'h321B, 32'h0000_0001, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF, 1'b1},
        '{16'h3D0B, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 32'h8000_0000, 1'b1},
        '{16'h355B, 32'h0000_0001, 32'h0000_0001, 1'b1, 32'h0000_0000, 1'b0},
        '{16'h4924, 32'h0000_0000, 32'h8000_0001, 1'b0, 32'h0000_0002, 1'b1},
        '{16'h4024, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0001, 1'b0}
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] insn;
    logic [31:0] rm_val;
    logic [31:0] rn_val;
    logic        t_in;
    logic        out_valid;
    logic        unsupported;
    logic [3:0]  rd_idx;
    logic [31:0] result;
    logic        t_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    tflag_alu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .insn        (insn),
        .rm_val      (rm_val),
        .rn_val      (rn_val),
        .t_in        (t_in),
        .out_valid   (out_valid),
        .unsupported (unsupported),
        .rd_idx      (rd_idx),
        .result      (result),
        .t_out       (t_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model on 33-bit and 64-bit arithmetic
    function automatic logic [32:0] model(input logic [15:0] op, input logic [31:0] rm,
                                          input logic [31:0] rn, input logic t);
        logic [32:0] w;
        longint      s;
        w = {rn, t};
        if (op[15:12] == 4'h3 && op[3:0] == 4'hE) begin
            w = {1'b0, rn} + {1'b0, rm} + {32'd0, t};
            w = {w[31:0], w[32]};
        end else if (op[15:12] == 4'h3 && op[3:0] == 4'hA) begin
            w = {1'b0, rn} - {1'b0, rm} - {32'd0, t};
            w = {w[31:0], w[32]};
        end else if (op[15:12] == 4'h6 && op[3:0] == 4'hA) begin
            w = 33'd0 - {1'b0, rm} - {32'd0, t};
            w = {w[31:0], w[32]};
        end else if (op[15:12] == 4'h3 && op[3:0] == 4'hF) begin
            s = longint'($signed(rn)) + longint'($signed(rm));
            w = {rn + rm, (s > 64'sd2147483647) || (s < -64'sd2147483648)};
        end else if (op[15:12] == 4'h3 && op[3:0] == 4'hB) begin
            s = longint'($signed(rn)) - longint'($signed(rm));
            w = {rn - rm, (s > 64'sd2147483647) || (s < -64'sd2147483648)};
        end else if (op[15:12] == 4'h4 && op[7:0] == 8'h24) begin
            w = {rn[30:0], t, rn[31]};
        end
        return w;
    endfunction

    task automatic apply(input logic [15:0] op, input logic [31:0] rm, input logic [31:0] rn, input logic t);
        @(negedge clk);
        in_valid = 1'b1;
        insn     = op;
        rm_val   = rm;
        rn_val   = rn;
        t_in     = t;
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [15:0] op);
        if (op[15:12] == 4'h3 && op[3:0] == 4'hE) return "R3";
        if (op[15:12] == 4'h3 && op[3:0] == 4'hA) return "R4";
        if (op[15:12] == 4'h6) return "R5";
        if (op[15:12] == 4'h3 && op[3:0] == 4'hF) return "R6";
        if (op[15:12] == 4'h3 && op[3:0] == 4'hB) return "R7";
        return "R8";
    endfunction

    initial begin
        logic [31:0] corner [4];
        logic [15:0] ops [6];
        logic [32:0] m;
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        ops[0] = 16'h3C7E; ops[1] = 16'h3C7A; ops[2] = 16'h6C7A;
        ops[3] = 16'h3C7F; ops[4] = 16'h3C7B; ops[5] = 16'h4C24;

        rst_n = 1'b0; in_valid = 1'b0; insn = '0; rm_val = '0; rn_val = '0; t_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({out_valid, unsupported, rd_idx, result, t_out} == '0, "R1 reset",
              {25'd0, out_valid, unsupported, rd_idx, result, t_out}, 64'd0);
        rst_n = 1'b1;

        // vector table, R2 destination index on each
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].op, VEC[i].rm, VEC[i].rn, VEC[i].t);
            check(result == VEC[i].er && t_out == VEC[i].et && out_valid && !unsupported,
                  req_of(VEC[i].op), {31'd0, t_out, result}, {31'd0, VEC[i].et, VEC[i].er});
            check(rd_idx == VEC[i].op[11:8], "R2 rd_idx", {60'd0, rd_idx}, {60'd0, VEC[i].op[11:8]});
        end

        // corner operands crossed with T against the model
        for (int o = 0; o < 6; o++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int tv = 0; tv < 2; tv++) begin
                        apply(ops[o], corner[a], corner[b], tv[0]);
                        m = model(ops[o], corner[a], corner[b], tv[0]);
                        check({result, t_out} == m && !unsupported, req_of(ops[o]),
                              {31'd0, result, t_out}, {31'd0, m});
                    end
                end
            end
        end

        // R6 and R7: incoming T has no effect on overflow forms
        apply(16'h301F, 32'h0000_0001, 32'h0000_0001, 1'b1);
        check(result == 32'h2 && !t_out, "R6 t ignored", {31'd0, t_out, result}, 64'h2);
        apply(16'h301B, 32'h0000_0003, 32'h0000_0005, 1'b1);
        check(result == 32'h2 && !t_out, "R7 t ignored", {31'd0, t_out, result}, 64'h2);

        // R9 unsupported words
        apply(16'h0009, 32'h1111_1111, 32'hCAFE_F00D, 1'b1);
        check(unsupported && out_valid && result == 32'hCAFE_F00D && t_out, "R9 nop",
              {30'd0, unsupported, t_out, result}, {30'd0, 2'b11, 32'hCAFE_F00D});
        apply(16'h300C, 32'h1111_1111, 32'h0BAD_0001, 1'b0);
        check(unsupported && result == 32'h0BAD_0001 && !t_out, "R9 other 3n",
              {30'd0, unsupported, t_out, result}, {30'd0, 2'b10, 32'h0BAD_0001});
        apply(16'h4025, 32'h0, 32'h8000_0000, 1'b0);
        check(unsupported && result == 32'h8000_0000 && !t_out, "R9 near rotate",
              {30'd0, unsupported, t_out, result}, {30'd0, 2'b10, 32'h8000_0000});

        // R10 idle
        @(negedge clk);
        in_valid = 1'b0;
        insn     = 16'h0009;
        @(negedge clk);
        check(!out_valid && !unsupported, "R10 idle", {62'd0, out_valid, unsupported}, 64'd0);

        // R1 latency: output holds previous input for one cycle
        apply(16'h300E, 32'h1, 32'h1, 1'b0);
        in_valid = 1'b0;
        check(result == 32'h2 && out_valid, "R1 latency", {31'd0, out_valid, result}, {31'd1, 32'h2});
        @(negedge clk);
        check(!out_valid, "R1 valid drop", {63'd0, out_valid}, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule